// File: doc/BRIEF.md
# Transmit Descriptor List Walker

This block follows a list of transmit descriptors held in host memory and turns each one into buffer-transfer commands for a downstream mover. A descriptor is four 32-bit words at consecutive word addresses. Word 0 carries an ownership flag. Word 1 is the control word, with two 11-bit byte counts, a chain flag and an end-of-ring flag. Word 2 is the first buffer pointer. Word 3 is either the second buffer pointer or the link to the next descriptor. The walker fetches the four words with single-outstanding reads, issues up to two commands (pointer plus byte count) on a valid/ready port, and then works out where the next descriptor sits.

Software writes the list base to `cfg_base` and pulses `cfg_start`. The walker runs until it meets a descriptor that the host still owns, or a link pointer that is not 16-byte aligned. It then pulses `walk_done`, together with `walk_err` in the second case, and returns to idle. Moving the data, sending frames, writing ownership back and raising interrupts belong to other blocks.

Top module: `txd_walker`

## Requirements
- R1: Each descriptor at address A is read in the order A, A+4, A+8, A+12. A new read request is raised only after the previous read has returned, and a request is held with its address unchanged until it is accepted.
- R2: The first byte count is control-word bits 10:0. When it is nonzero, a command with `cmd_sel`=0, `cmd_addr`=word 2 and `cmd_len`=that count is issued. When it is zero, no buffer-1 command is issued and handling moves straight on to buffer 2.
- R3: Buffer pointers reach `cmd_addr` exactly as read, including odd byte addresses. Within a descriptor the buffer-1 command always comes before the buffer-2 command. A command is held stable while `cmd_valid` is high and `cmd_ready` is low.
- R4: Control-word bit 24 is the chain flag. When it is set and end of ring is clear, no buffer-2 command is issued and the next descriptor address is word 3.
- R5: The second byte count is control-word bits 21:11. When the descriptor is not chained and this count is nonzero, a command with `cmd_sel`=1, `cmd_addr`=word 3 and `cmd_len`=that count is issued. When the count is zero, no buffer-2 command is issued.
- R6: Control-word bit 25 marks end of ring. It overrides the chain flag, so word 3 is treated as a buffer-2 pointer, and the next descriptor address returns to the latched base.
- R7: With neither flag set, the next descriptor address is the current address plus 16.
- R8: A chained link whose low four bits are nonzero ends the walk, with `walk_err` and `walk_done` pulsing high together for one cycle. No further read is made.
- R9: If bit 31 of word 0 reads as zero, the walk ends after that single read with a one-cycle `walk_done` pulse, `walk_err` low and no command for that descriptor.
- R10: `cfg_start` acts only while the walker is idle. The walker then latches `cfg_base` with its low four bits cleared and starts there. A start pulse during a walk has no effect.
- R11: After reset, `walk_busy`, `walk_done`, `walk_err`, `mem_req_valid` and `cmd_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 32 | Address of the first descriptor in the list |
| cfg_start | input | 1 | One-cycle pulse that starts a walk |
| walk_busy | output | 1 | High while a walk is in progress |
| walk_done | output | 1 | One-cycle pulse when a walk ends |
| walk_err | output | 1 | Pulses together with walk_done when a link is misaligned |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| cmd_valid | output | 1 | Buffer command valid |
| cmd_ready | input | 1 | Buffer command accepted |
| cmd_addr | output | 32 | Buffer byte address |
| cmd_len | output | 11 | Buffer byte count |
| cmd_sel | output | 1 | 0 for buffer 1, 1 for buffer 2 |

## Verification
Random memory images fill every descriptor slot with random ownership, byte counts that are often zero, and chain and end-of-ring flags, with links that are sometimes misaligned. Random ready and response delays are applied, and the bench compares the full stream of read addresses and commands against a reference walk. Because the bench memory clears a descriptor's ownership flag on its first visit, ring wraps and chain loops always end, and a wrong next-address choice shows up as a wrong read address rather than a hang. Directed images separate the cases that random stimulus rarely isolates: zero buffer-1 size, odd pointers, a chain that skips buffer 2, end of ring overriding the chain flag, a misaligned link, a host-owned first descriptor and an unaligned base. A stray start pulse during a walk shows whether the base is wrongly re-latched.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int LEN_W      = 11;
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int BYTE_SH    = $clog2(WORD_BYTES);
    localparam int DESC_BYTES = DESC_WORDS * WORD_BYTES;
    localparam int ALIGN_W    = $clog2(DESC_BYTES);

    // bit positions decoded from the descriptor words
    localparam int OWN_BIT   = 31;
    localparam int LEN1_LSB  = 0;
    localparam int LEN2_LSB  = 11;
    localparam int CHAIN_BIT = 24;
    localparam int RING_BIT  = 25;

    typedef logic [DESC_WORDS-1:0][WORD_W-1:0] desc_words_t;

    typedef enum logic {
        SEL_BUF1 = 1'b0,
        SEL_BUF2 = 1'b1
    } buf_sel_e;

    typedef struct packed {
        logic              last_in_ring;
        logic              linked;       // chain flag with end-of-ring not set
        logic [LEN_W-1:0]  len1;
        logic [LEN_W-1:0]  len2;
        logic [ADDR_W-1:0] ptr1;
        logic [ADDR_W-1:0] ptr2;
    } desc_info_t;

    typedef struct packed {
        buf_sel_e          sel;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] addr;
    } buf_cmd_t;

    function automatic desc_info_t decode_desc(input desc_words_t w);
        desc_info_t d;
        d.last_in_ring = w[1][RING_BIT];
        d.linked       = w[1][CHAIN_BIT] & ~w[1][RING_BIT];
        d.len1         = w[1][LEN1_LSB +: LEN_W];
        d.len2         = w[1][LEN2_LSB +: LEN_W];
        d.ptr1         = w[2];
        d.ptr2         = w[3];
        return d;
    endfunction

    function automatic logic wants_buf2(input desc_info_t d);
        return ~d.linked & (d.len2 != '0);
    endfunction

    function automatic logic [ADDR_W-1:0] desc_align(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/txd_fetch.sv
module txd_fetch
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] desc_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output desc_words_t       words,
    output logic              fetch_done,
    output logic              host_owned
);

    typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fstate_e;

    fstate_e           st;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] base_q;

    assign mem_req_valid = (st == F_REQ);
    assign mem_req_addr  = base_q + ADDR_W'({idx, {BYTE_SH{1'b0}}});

    // one capture register per descriptor word
    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
            end else if (st == F_WAIT && mem_rsp_valid && idx == IDX_W'(g)) begin
                words[g] <= mem_rsp_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= F_IDLE;
            idx        <= '0;
            base_q     <= '0;
            fetch_done <= 1'b0;
            host_owned <= 1'b0;
        end else begin
            fetch_done <= 1'b0;
            host_owned <= 1'b0;
            case (st)
                F_IDLE: begin
                    if (go) begin
                        base_q <= desc_addr;
                        idx    <= '0;
                        st     <= F_REQ;
                    end
                end
                F_REQ: begin
                    if (mem_req_ready) begin
                        st <= F_WAIT;
                    end
                end
                F_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (idx == '0 && !mem_rsp_data[OWN_BIT]) begin
                            host_owned <= 1'b1;
                            st         <= F_IDLE;
                        end else if (idx == IDX_W'(DESC_WORDS - 1)) begin
                            fetch_done <= 1'b1;
                            st         <= F_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= F_REQ;
                        end
                    end
                end
                default: st <= F_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/txd_emit.sv
module txd_emit
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  desc_info_t        desc,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output buf_cmd_t          cmd,
    output logic              emit_done
);

    typedef enum logic [1:0] {E_IDLE, E_BUF1, E_BUF2} estate_e;

    estate_e    st;
    desc_info_t d_q;

    assign cmd_valid = (st == E_BUF1) || (st == E_BUF2);

    always_comb begin
        if (st == E_BUF2) begin
            cmd.sel  = SEL_BUF2;
            cmd.len  = d_q.len2;
            cmd.addr = d_q.ptr2;
        end else begin
            cmd.sel  = SEL_BUF1;
            cmd.len  = d_q.len1;
            cmd.addr = d_q.ptr1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= E_IDLE;
            d_q       <= '0;
            emit_done <= 1'b0;
        end else begin
            emit_done <= 1'b0;
            case (st)
                E_IDLE: begin
                    if (go) begin
                        d_q <= desc;
                        if (desc.len1 != '0) begin
                            st <= E_BUF1;
                        end else if (wants_buf2(desc)) begin
                            st <= E_BUF2;
                        end else begin
                            emit_done <= 1'b1;
                        end
                    end
                end
                E_BUF1: begin
                    if (cmd_ready) begin
                        if (wants_buf2(d_q)) begin
                            st <= E_BUF2;
                        end else begin
                            emit_done <= 1'b1;
                            st        <= E_IDLE;
                        end
                    end
                end
                E_BUF2: begin
                    if (cmd_ready) begin
                        emit_done <= 1'b1;
                        st        <= E_IDLE;
                    end
                end
                default: st <= E_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/txd_nextaddr.sv
module txd_nextaddr
    import txd_pkg::*;
(
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] ring_base,
    input  desc_info_t        desc,
    output logic [ADDR_W-1:0] next_addr,
    output logic              link_misaligned
);

    always_comb begin
        if (desc.last_in_ring) begin
            next_addr = ring_base;
        end else if (desc.linked) begin
            next_addr = desc.ptr2;
        end else begin
            next_addr = cur_addr + ADDR_W'(DESC_BYTES);
        end
        link_misaligned = desc.linked && (desc.ptr2[ALIGN_W-1:0] != '0);
    end

endmodule

// File: rtl/txd_walker.sv
module txd_walker
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_start,
    output logic              walk_busy,
    output logic              walk_done,
    output logic              walk_err,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_sel
);

    typedef enum logic [1:0] {T_IDLE, T_FETCH, T_EMIT, T_ADV} tstate_e;

    tstate_e           st;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] cur_q;
    desc_info_t        desc_q;
    desc_info_t        desc_new;
    desc_words_t       words;
    buf_cmd_t          cmd;
    logic              fetch_go;
    logic [ADDR_W-1:0] fetch_addr;
    logic              fetch_done;
    logic              host_owned;
    logic              emit_go;
    logic              emit_done;
    logic [ADDR_W-1:0] next_addr;
    logic              misaligned;

    assign desc_new  = decode_desc(words);
    assign walk_busy = (st != T_IDLE);
    assign emit_go   = (st == T_FETCH) && fetch_done;

    always_comb begin
        fetch_go   = 1'b0;
        fetch_addr = next_addr;
        if (st == T_IDLE && cfg_start) begin
            fetch_go   = 1'b1;
            fetch_addr = desc_align(cfg_base);
        end else if (st == T_ADV && !misaligned) begin
            fetch_go = 1'b1;
        end
    end

    txd_fetch u_fetch (
        .clk           (clk),
        .rst           (rst),
        .go            (fetch_go),
        .desc_addr     (fetch_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .words         (words),
        .fetch_done    (fetch_done),
        .host_owned    (host_owned)
    );

    txd_emit u_emit (
        .clk       (clk),
        .rst       (rst),
        .go        (emit_go),
        .desc      (desc_new),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd       (cmd),
        .emit_done (emit_done)
    );

    txd_nextaddr u_next (
        .cur_addr        (cur_q),
        .ring_base       (base_q),
        .desc            (desc_q),
        .next_addr       (next_addr),
        .link_misaligned (misaligned)
    );

    assign cmd_addr = cmd.addr;
    assign cmd_len  = cmd.len;
    assign cmd_sel  = cmd.sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= T_IDLE;
            base_q    <= '0;
            cur_q     <= '0;
            desc_q    <= '0;
            walk_done <= 1'b0;
            walk_err  <= 1'b0;
        end else begin
            walk_done <= 1'b0;
            walk_err  <= 1'b0;
            case (st)
                T_IDLE: begin
                    if (cfg_start) begin
                        base_q <= desc_align(cfg_base);
                        cur_q  <= desc_align(cfg_base);
                        st     <= T_FETCH;
                    end
                end
                T_FETCH: begin
                    if (host_owned) begin
                        walk_done <= 1'b1;
                        st        <= T_IDLE;
                    end else if (fetch_done) begin
                        desc_q <= desc_new;
                        st     <= T_EMIT;
                    end
                end
                T_EMIT: begin
                    if (emit_done) begin
                        st <= T_ADV;
                    end
                end
                T_ADV: begin
                    if (misaligned) begin
                        walk_done <= 1'b1;
                        walk_err  <= 1'b1;
                        st        <= T_IDLE;
                    end else begin
                        cur_q <= next_addr;
                        st    <= T_FETCH;
                    end
                end
                default: st <= T_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/txd_walker_chk.sv
module txd_walker_chk
    import txd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              walk_busy,
    input logic              walk_done,
    input logic              walk_err,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [LEN_W-1:0]  cmd_len,
    input logic              cmd_sel
);

    logic read_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            read_open <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            read_open <= 1'b1;
        end else if (mem_rsp_valid) begin
            read_open <= 1'b0;
        end
    end

    p_single_read_r1: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !read_open);

    p_req_hold_r1: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_req_word_aligned_r1: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_addr[BYTE_SH-1:0] == '0);

    p_cmd_hold_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr)
            && $stable(cmd_len) && $stable(cmd_sel));

    p_cmd_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd_len != '0);

    p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && mem_req_valid));

    p_err_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        walk_err |-> walk_done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        walk_done |-> !walk_busy && !mem_req_valid && !cmd_valid);

endmodule

bind txd_walker txd_walker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .walk_busy     (walk_busy),
    .walk_done     (walk_done),
    .walk_err      (walk_err),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_addr      (cmd_addr),
    .cmd_len       (cmd_len),
    .cmd_sel       (cmd_sel)
);

// File: tb/sim_txd_walker.sv
`timescale 1ns/1ps
module sim_txd_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_base = '0;
    logic        cfg_start = 1'b0;
    logic        walk_busy, walk_done, walk_err;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_addr;
    logic [10:0] cmd_len;
    logic        cmd_sel;

    always #2 clk = ~clk;

    txd_walker u0 (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_start(cfg_start),
        .walk_busy(walk_busy), .walk_done(walk_done), .walk_err(walk_err),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_sel(cmd_sel)
    );

    int checks = 0;
    int failures = 0;
    int run_fail = 0;
    int cmd_seen = 0;
    bit got_done = 0;
    bit got_err = 0;
    bit finished = 0;

    logic [31:0] mem   [256];
    logic [31:0] mem_m [256];
    logic [31:0] exp_fetch[$];
    logic [43:0] exp_cmd[$];
    bit          exp_err;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            run_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int widx(input logic [31:0] a);
        return int'(a[9:2]);
    endfunction

    // reference walk over a private copy of memory
    task automatic model_walk(input logic [31:0] base_in);
        logic [31:0] base, cur, w0, w1, w2, w3;
        logic [10:0] l1, l2;
        bit link, eor;
        exp_fetch.delete();
        exp_cmd.delete();
        exp_err = 0;
        for (int i = 0; i < 256; i++) mem_m[i] = mem[i];
        base = {base_in[31:4], 4'h0};
        cur  = base;
        for (int n = 0; n < 300; n++) begin
            exp_fetch.push_back(cur);
            w0 = mem_m[widx(cur)];
            if (!w0[31]) break;
            mem_m[widx(cur)][31] = 1'b0;
            exp_fetch.push_back(cur + 4);
            exp_fetch.push_back(cur + 8);
            exp_fetch.push_back(cur + 12);
            w1 = mem_m[widx(cur + 4)];
            w2 = mem_m[widx(cur + 8)];
            w3 = mem_m[widx(cur + 12)];
            l1 = w1[10:0];
            l2 = w1[21:11];
            eor  = w1[25];
            link = w1[24] && !eor;
            if (l1 != 0) exp_cmd.push_back({1'b0, l1, w2});
            if (!link && l2 != 0) exp_cmd.push_back({1'b1, l2, w3});
            if (link && w3[3:0] != 0) begin
                exp_err = 1;
                break;
            end
            cur = eor ? base : (link ? w3 : cur + 16);
        end
    endtask

    // memory and command sink: everything decided at the falling edge
    initial begin
        bit pend = 0;
        int cnt = 0;
        logic [31:0] raddr = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem[widx(raddr)];
                    if (raddr[3:0] == 4'h0) mem[widx(raddr)][31] = 1'b0;
                    pend = 0;
                end else begin
                    cnt--;
                end
            end
            mem_req_ready = ($urandom % 4) != 0;
            if (!rst && mem_req_valid && mem_req_ready) begin
                if (exp_fetch.size() == 0) begin
                    check(0, "R1", "unexpected read", {32'h0, mem_req_addr}, 64'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_fetch.pop_front();
                    check(mem_req_addr == e, "R1", "read address", {32'h0, mem_req_addr}, {32'h0, e});
                end
                raddr = mem_req_addr;
                pend  = 1;
                cnt   = $urandom % 3;
            end
            cmd_ready = ($urandom % 4) != 0;
            if (!rst && cmd_valid && cmd_ready) begin
                cmd_seen++;
                if (exp_cmd.size() == 0) begin
                    check(0, "R2", "unexpected command", {20'h0, cmd_sel, cmd_len, cmd_addr}, 64'h0);
                end else begin
                    logic [43:0] e;
                    e = exp_cmd.pop_front();
                    check({cmd_sel, cmd_len, cmd_addr} == e, e[43] ? "R5" : "R2",
                          "command sel/len/addr", {20'h0, cmd_sel, cmd_len, cmd_addr}, {20'h0, e});
                end
            end
            if (walk_done) begin
                got_done = 1;
                got_err  = walk_err;
            end
        end
    end

    task automatic run_walk(input logic [31:0] base, input string req,
                            input int exp_ncmd, input bit poke);
        model_walk(base);
        run_fail = 0;
        cmd_seen = 0;
        got_done = 0;
        @(negedge clk);
        cfg_base  = base;
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            if (walk_busy && !got_done) begin
                cfg_base  = base ^ 32'h0000_0200;
                cfg_start = 1'b1;
                @(negedge clk);
                cfg_start = 1'b0;
            end
        end
        wait (got_done);
        @(negedge clk);
        check(got_err == exp_err, "R8", "error flag at end", {63'h0, got_err}, {63'h0, exp_err});
        check(exp_fetch.size() == 0, "R1", "reads left", exp_fetch.size(), 0);
        check(exp_cmd.size() == 0, req, "commands left", exp_cmd.size(), 0);
        if (exp_ncmd >= 0)
            check(cmd_seen == exp_ncmd, req, "command count", cmd_seen, exp_ncmd);
        if (poke)
            check(run_fail == 0, "R10", "walk disturbed by start pulse", run_fail, 0);
    endtask

    function automatic logic [31:0] ctl(input logic [10:0] l1, input logic [10:0] l2,
                                        input bit ch, input bit eor);
        logic [31:0] w;
        w = 32'h0;
        w[10:0]  = l1;
        w[21:11] = l2;
        w[24]    = ch;
        w[25]    = eor;
        return w;
    endfunction

    task automatic put_desc(input logic [31:0] a, input bit own, input logic [31:0] w1,
                            input logic [31:0] w2, input logic [31:0] w3);
        mem[widx(a)]      = {own, 31'h1};
        mem[widx(a + 4)]  = w1;
        mem[widx(a + 8)]  = w2;
        mem[widx(a + 12)] = w3;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    endtask

    task automatic random_mem();
        for (int s = 0; s < 64; s++) begin
            logic [31:0] w1, w3;
            bit ch;
            ch = ($urandom % 3) == 0;
            w1 = $urandom;
            w1[10:0]  = (($urandom % 4) == 0) ? 11'h0 : 11'($urandom);
            w1[21:11] = (($urandom % 4) == 0) ? 11'h0 : 11'($urandom);
            w1[24] = ch;
            w1[25] = ($urandom % 8) == 0;
            if (ch) begin
                w3 = {22'h0, 6'($urandom), 4'h0};
                if (($urandom % 8) == 0) w3[3:0] = 4'(1 + $urandom % 15);
            end else begin
                w3 = $urandom;
            end
            mem[s*4]     = {($urandom % 8) != 0, 31'($urandom)};
            mem[s*4 + 1] = w1;
            mem[s*4 + 2] = $urandom;
            mem[s*4 + 3] = w3;
        end
    endtask

    initial begin
        void'($urandom(32'd20250417));
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clear_mem();
        repeat (4) @(negedge clk);
        // R11: reset state
        check({walk_busy, walk_done, walk_err, mem_req_valid, cmd_valid} == 5'b0,
              "R11", "outputs in reset", {59'h0, walk_busy, walk_done, walk_err, mem_req_valid, cmd_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check({walk_busy, walk_done, walk_err, mem_req_valid, cmd_valid} == 5'b0,
              "R11", "outputs after reset", {59'h0, walk_busy, walk_done, walk_err, mem_req_valid, cmd_valid}, 0);

        // R2 + R10: zero buffer-1 size, unaligned base 0x4B starts at 0x40
        clear_mem();
        put_desc(32'h40, 1, ctl(11'd0, 11'd5, 0, 0), 32'h1111_1111, 32'h2222_2223);
        run_walk(32'h4B, "R2", 1, 0);

        // R3 + R7: odd pointers, ring step of 16 then host-owned stop
        clear_mem();
        put_desc(32'h100, 1, ctl(11'd3, 11'd9, 0, 0), 32'h1234_5677, 32'hDEAD_BEEF);
        put_desc(32'h110, 1, ctl(11'd2047, 11'd0, 0, 0), 32'h0000_0001, 32'h5);
        run_walk(32'h100, "R3", 3, 0);

        // R4 + R5: chained link skips buffer 2; zero size 2 in ring mode
        clear_mem();
        put_desc(32'h200, 1, ctl(11'd4, 11'd7, 1, 0), 32'hA000_0000, 32'h300);
        put_desc(32'h300, 1, ctl(11'd2, 11'd0, 0, 0), 32'hB000_0003, 32'hFFFF_FFFF);
        run_walk(32'h200, "R4", 2, 0);

        // R6: end of ring overrides chain and wraps to base
        clear_mem();
        put_desc(32'h80, 1, ctl(11'd1, 11'd0, 0, 0), 32'hC000_0000, 32'h0);
        put_desc(32'h90, 1, ctl(11'd0, 11'd6, 1, 1), 32'h0, 32'h305);
        run_walk(32'h80, "R6", 2, 0);

        // R8: misaligned chained link
        clear_mem();
        put_desc(32'h0, 1, ctl(11'd0, 11'd3, 1, 0), 32'h0, 32'h208);
        run_walk(32'h0, "R8", 0, 0);

        // R9: first descriptor still host-owned
        clear_mem();
        put_desc(32'h3C0, 0, ctl(11'd8, 11'd8, 0, 0), 32'h10, 32'h20);
        run_walk(32'h3C0, "R9", 0, 0);

        // random lists, some with a stray start pulse (R10)
        for (int r = 0; r < 24; r++) begin
            random_mem();
            run_walk($urandom & 32'h3FF, "R5", -1, (r % 3) == 0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule